// File: doc/BRIEF.md
# Block-Cipher Register Front End

This block is the memory-mapped register shell around a 128-bit block-cipher engine. Software or a DMA engine loads a key of up to eight 32-bit words and a four-word chaining vector, chooses a mode in a control register, and then streams payload through one data port. Four data-port writes fill one 16-byte block, which is handed to the cipher engine over a start/done handshake. The engine's result is returned through four data-port reads. The engine itself, meaning the rounds and the key schedule, sits outside this block.

When chaining mode is selected, the front end applies the chaining XOR itself and keeps the chaining vector up to date, so consecutive blocks can be streamed back to back. Two ready flags tell the host when to write and when to read. The same flags drive two packet DMA request lines, which are allowed out only while a start bit is set. A soft reset bit wipes every register over a fixed number of cycles, and a status bit shows when the wipe has finished.

Top module: `cipher_regfront`

## Requirements
- R1: Key word i (0..7) lives at byte offset 0x1C - ((i XOR 1) * 4), so word 0 is at 0x18, word 1 at 0x1C and word 7 at 0x04. Every key word reads back at its offset. Key word i drives bits 32i+31:32i of `core_key`.
- R2: The control register is at 0x30. Bits 7:2 are writable and read back: bit 7 is counter width, bit 6 is counter mode, bit 5 selects chaining, bits 4:3 hold the key size code (key bytes / 8 - 1), and bit 2 selects direction (1 = encrypt). Bit 1 reads the input-ready flag and bit 0 reads the output-ready flag, and writes to these two bits have no effect. Bits 4:3 drive `core_keysz` and bit 2 drives `core_encrypt`.
- R3: The revision register at 0x44 reads the major number in bits 7:4 and the minor number in bits 3:0. With the default parameters it reads 0x21.
- R4: Writes to any data-port offset (0x34 to 0x40) fill the input block in arrival order, and the first word written lands in bits 31:0. Input ready is 1 only while no word of a block has been collected. In the cycle after the fourth write, `core_start` is high for exactly one cycle and input ready is 0.
- R5: A done pulse from the engine sets output ready. Four data-port reads then return the result words in order, starting with bits 31:0. After the fourth read, output ready clears and input ready returns.
- R6: In chaining encrypt mode, the engine receives the input block XORed with the chaining vector, and the chaining vector becomes the engine's output.
- R7: In chaining decrypt mode, the result is the engine's output XORed with the chaining vector, and the chaining vector becomes the received input block. The chaining vector words read back at 0x20, 0x24, 0x28 and 0x2C, in bits 31:0 first order.
- R8: Data-port writes that arrive while the engine is busy or while a result is waiting to be read are ignored.
- R9: The mask register is at 0x48, with bit 5 = start, bit 3 = DMA-out enable and bit 2 = DMA-in enable. `dma_in_req` equals start AND DMA-in enable AND input ready. `dma_out_req` equals start AND DMA-out enable AND output ready. Clearing start drops both requests.
- R10: Writing 1 to mask bit 1 starts a soft reset lasting `RST_CYCLES` cycles. While it runs, status bit 0 at 0x4C reads 0, mask bit 1 reads 1, both ready flags are 0, and bus writes are ignored. When it ends, every register is cleared, mask bit 1 reads 0 again, and status bit 0 reads 1.
- R11: After a hardware reset, status reads 1, control reads 0x02 (input ready only), mask reads 0, and the key and chaining registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte address |
| bus_wr | input | 1 | Write strobe, single cycle |
| bus_rd | input | 1 | Read strobe, single cycle |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data, valid in the same cycle as the address |
| in_rdy | output | 1 | Ready to accept a new input block |
| out_rdy | output | 1 | Result block waiting to be read |
| dma_in_req | output | 1 | Packet request toward the data port (write side) |
| dma_out_req | output | 1 | Packet request from the data port (read side) |
| core_start | output | 1 | One-cycle start pulse to the engine |
| core_in | output | WORD_W*BLK_WORDS | Block presented to the engine |
| core_key | output | WORD_W*KEY_WORDS | Key words, word 0 in the low bits |
| core_keysz | output | 2 | Key size code |
| core_encrypt | output | 1 | Direction, 1 = encrypt |
| core_done | input | 1 | Engine finished, one-cycle pulse |
| core_out | input | WORD_W*BLK_WORDS | Engine result block |

## Verification
The main path is driven from a table of five blocks that cover plain encrypt, two chained encrypts in a row, a chained decrypt and a plain decrypt. The two chained encrypts in a row would expose a chaining vector that failed to update. The decrypt entry tells apart a vector refreshed from the ciphertext from one refreshed from the engine output. For every block, the bench checks the word presented to the engine as well as the word read back, so a missing input XOR cannot hide behind a matching output. The stub engine folds in all eight key words, so a wrong key-address scramble changes every result.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
   // register word indexes (byte offset / 4); the map is software visible
   localparam int WI_IV0    = 8;
   localparam int WI_CTRL   = 12;
   localparam int WI_DATA0  = 13;
   localparam int WI_DATA1  = 16;
   localparam int WI_REV    = 17;
   localparam int WI_MASK   = 18;
   localparam int WI_STAT   = 19;

   // control bit positions
   localparam int CB_CBC    = 5;
   localparam int CB_KSZ_LO = 3;
   localparam int CB_ENC    = 2;

   // mask bit positions
   localparam int MB_GO     = 5;
   localparam int MB_DOUT   = 3;
   localparam int MB_DIN    = 2;
   localparam int MB_SRST   = 1;

   // storable bits of the mask register (smart idle, start, dma out, dma in, autoidle)
   localparam logic [7:0] MASK_STORE = 8'h6D;
endpackage

// File: rtl/cfe_rst_seq.sv
module cfe_rst_seq #(
   parameter int HOLD = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   output logic active
);
   localparam int CNT_W = $clog2(HOLD + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (kick && cnt == '0)
         cnt <= CNT_W'(HOLD);
      else if (cnt != '0)
         cnt <= cnt - CNT_W'(1);
   end

   assign active = (cnt != '0);
endmodule

// File: rtl/cfe_keybank.sv
module cfe_keybank #(
   parameter int WORD_W    = 32,
   parameter int KEY_WORDS = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        we,
   input  logic [$clog2(KEY_WORDS)-1:0] sel,
   input  logic [WORD_W-1:0]           wdata,
   output logic [WORD_W-1:0]           rdata,
   output logic [WORD_W*KEY_WORDS-1:0] key_flat
);
   localparam int KW = $clog2(KEY_WORDS);

   logic [WORD_W-1:0] kreg [KEY_WORDS];
   logic [KW-1:0]     slot;

   // offsets descend from the top word, neighbouring pairs swapped
   assign slot = (KW'(KEY_WORDS - 1) - sel) ^ KW'(1);

   for (genvar g = 0; g < KEY_WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            kreg[g] <= '0;
         else if (clr)
            kreg[g] <= '0;
         else if (we && slot == KW'(g))
            kreg[g] <= wdata;
      end
      assign key_flat[g*WORD_W +: WORD_W] = kreg[g];
   end

   assign rdata = kreg[slot];
endmodule

// File: rtl/cfe_chain.sv
module cfe_chain #(
   parameter int BW       = 128,
   parameter bit CHAIN_EN = 1'b1
) (
   input  logic          cbc,
   input  logic          enc,
   input  logic [BW-1:0] iv,
   input  logic [BW-1:0] raw_in,
   input  logic [BW-1:0] core_res,
   output logic [BW-1:0] to_core,
   output logic [BW-1:0] result,
   output logic [BW-1:0] iv_next
);
   if (CHAIN_EN) begin : g_cbc
      always_comb begin
         to_core = raw_in;
         result  = core_res;
         iv_next = iv;
         if (cbc) begin
            if (enc) begin
               to_core = raw_in ^ iv;
               iv_next = core_res;
            end else begin
               result  = core_res ^ iv;
               iv_next = raw_in;
            end
         end
      end
   end else begin : g_plain
      assign to_core = raw_in;
      assign result  = core_res;
      assign iv_next = iv;
   end
endmodule

// File: rtl/cipher_regfront.sv
module cipher_regfront
   import cfe_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int BLK_WORDS  = 4,
   parameter int KEY_WORDS  = 8,
   parameter int AW         = 8,
   parameter int RST_CYCLES = 8,
   parameter int REV_MAJOR  = 2,
   parameter int REV_MINOR  = 1,
   parameter bit HAS_CBC    = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [AW-1:0]               bus_addr,
   input  logic                        bus_wr,
   input  logic                        bus_rd,
   input  logic [WORD_W-1:0]           bus_wdata,
   output logic [WORD_W-1:0]           bus_rdata,
   output logic                        in_rdy,
   output logic                        out_rdy,
   output logic                        dma_in_req,
   output logic                        dma_out_req,
   output logic                        core_start,
   output logic [WORD_W*BLK_WORDS-1:0] core_in,
   output logic [WORD_W*KEY_WORDS-1:0] core_key,
   output logic [1:0]                  core_keysz,
   output logic                        core_encrypt,
   input  logic                        core_done,
   input  logic [WORD_W*BLK_WORDS-1:0] core_out
);
   localparam int BLK_W = WORD_W * BLK_WORDS;
   localparam int CW    = $clog2(BLK_WORDS);
   localparam int KW    = $clog2(KEY_WORDS);
   localparam logic [CW-1:0] LAST_W   = CW'(BLK_WORDS - 1);
   localparam logic [7:0]    REV_BYTE = 8'((REV_MAJOR % 16) * 16 + (REV_MINOR % 16));

   if (BLK_WORDS != 4) begin : g_bad_blk
      $error("BLK_WORDS must be 4: one 128-bit block is four words");
   end
   if (KEY_WORDS != 8) begin : g_bad_key
      $error("KEY_WORDS must be 8 to fit the key window below the chaining words");
   end
   if (WORD_W != 32) begin : g_bad_word
      $error("WORD_W must be 32");
   end
   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("RST_CYCLES must be at least 1");
   end
   if (AW < 7) begin : g_bad_aw
      $error("AW too small for the register window");
   end

   // ---------------- decode ----------------
   logic [31:0] wsel;
   logic        aligned, wr_ok, data_hit, iv_hit, key_hit;
   logic        accept_in, last_in, drain, done_ok, srst_kick, rst_act;

   assign wsel      = 32'(bus_addr[AW-1:2]);
   assign aligned   = (bus_addr[1:0] == 2'b00);
   assign wr_ok     = bus_wr && aligned && !rst_act;
   assign key_hit   = (wsel < KEY_WORDS);
   assign iv_hit    = (wsel >= WI_IV0) && (wsel < WI_IV0 + BLK_WORDS);
   assign data_hit  = (wsel >= WI_DATA0) && (wsel <= WI_DATA1);
   assign srst_kick = wr_ok && (wsel == WI_MASK) && bus_wdata[MB_SRST];

   // ---------------- state ----------------
   logic [7:2]        ctrl_q;
   logic [7:0]        mask_q;
   logic [WORD_W-1:0] iv_q  [BLK_WORDS];
   logic [WORD_W-1:0] in_w  [BLK_WORDS];
   logic [WORD_W-1:0] out_w [BLK_WORDS];
   logic [CW-1:0]     in_cnt, out_cnt;
   logic              busy_q, full_q, start_q;
   logic [BLK_W-1:0]  iv_flat, in_flat, res_flat, iv_nx;
   logic [WORD_W-1:0] key_rd;

   assign accept_in = wr_ok && data_hit && !busy_q && !full_q;
   assign last_in   = accept_in && (in_cnt == LAST_W);
   assign drain     = bus_rd && aligned && data_hit && full_q && !rst_act;
   assign done_ok   = core_done && busy_q && !rst_act;

   cfe_rst_seq #(.HOLD(RST_CYCLES)) u_rst (
      .clk    (clk),
      .rst_n  (rst_n),
      .kick   (srst_kick),
      .active (rst_act)
   );

   cfe_keybank #(.WORD_W(WORD_W), .KEY_WORDS(KEY_WORDS)) u_keys (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (rst_act),
      .we       (wr_ok && key_hit),
      .sel      (wsel[KW-1:0]),
      .wdata    (bus_wdata),
      .rdata    (key_rd),
      .key_flat (core_key)
   );

   cfe_chain #(.BW(BLK_W), .CHAIN_EN(HAS_CBC)) u_chain (
      .cbc      (ctrl_q[CB_CBC]),
      .enc      (ctrl_q[CB_ENC]),
      .iv       (iv_flat),
      .raw_in   (in_flat),
      .core_res (core_out),
      .to_core  (core_in),
      .result   (res_flat),
      .iv_next  (iv_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mask_q <= '0;
      end else if (rst_act) begin
         ctrl_q <= '0;
         mask_q <= '0;
      end else if (wr_ok && wsel == WI_CTRL) begin
         ctrl_q <= bus_wdata[7:2];
      end else if (wr_ok && wsel == WI_MASK) begin
         mask_q <= bus_wdata[7:0] & MASK_STORE;
      end
   end

   for (genvar g = 0; g < BLK_WORDS; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            iv_q[g]  <= '0;
            in_w[g]  <= '0;
            out_w[g] <= '0;
         end else if (rst_act) begin
            iv_q[g]  <= '0;
            in_w[g]  <= '0;
            out_w[g] <= '0;
         end else begin
            if (done_ok && ctrl_q[CB_CBC])
               iv_q[g] <= iv_nx[g*WORD_W +: WORD_W];
            else if (wr_ok && wsel == WI_IV0 + g)
               iv_q[g] <= bus_wdata;
            if (accept_in && in_cnt == CW'(g))
               in_w[g] <= bus_wdata;
            if (done_ok)
               out_w[g] <= res_flat[g*WORD_W +: WORD_W];
         end
      end
      assign iv_flat[g*WORD_W +: WORD_W] = iv_q[g];
      assign in_flat[g*WORD_W +: WORD_W] = in_w[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_cnt  <= '0;
         out_cnt <= '0;
         busy_q  <= 1'b0;
         full_q  <= 1'b0;
         start_q <= 1'b0;
      end else if (rst_act) begin
         in_cnt  <= '0;
         out_cnt <= '0;
         busy_q  <= 1'b0;
         full_q  <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= last_in;
         if (accept_in)
            in_cnt <= last_in ? '0 : in_cnt + CW'(1);
         if (last_in)
            busy_q <= 1'b1;
         else if (done_ok)
            busy_q <= 1'b0;
         if (done_ok) begin
            full_q  <= 1'b1;
            out_cnt <= '0;
         end else if (drain) begin
            out_cnt <= (out_cnt == LAST_W) ? '0 : out_cnt + CW'(1);
            if (out_cnt == LAST_W)
               full_q <= 1'b0;
         end
      end
   end

   // ---------------- outputs ----------------
   assign in_rdy       = !rst_act && !busy_q && !full_q && (in_cnt == '0);
   assign out_rdy      = !rst_act && full_q;
   assign dma_in_req   = mask_q[MB_GO] && mask_q[MB_DIN] && in_rdy;
   assign dma_out_req  = mask_q[MB_GO] && mask_q[MB_DOUT] && out_rdy;
   assign core_start   = start_q;
   assign core_keysz   = ctrl_q[CB_KSZ_LO+1:CB_KSZ_LO];
   assign core_encrypt = ctrl_q[CB_ENC];

   always_comb begin
      bus_rdata = '0;
      if (aligned) begin
         if (key_hit)
            bus_rdata = key_rd;
         else if (iv_hit)
            bus_rdata = iv_q[wsel[CW-1:0]];
         else if (wsel == WI_CTRL)
            bus_rdata[7:0] = {ctrl_q, in_rdy, out_rdy};
         else if (data_hit)
            bus_rdata = full_q ? out_w[out_cnt] : '0;
         else if (wsel == WI_REV)
            bus_rdata[7:0] = REV_BYTE;
         else if (wsel == WI_MASK)
            bus_rdata[7:0] = mask_q | {6'b0, rst_act, 1'b0};
         else if (wsel == WI_STAT)
            bus_rdata[0] = !rst_act;
      end
   end
endmodule

// File: rtl/cfe_chk.sv
module cfe_chk (
   input logic clk,
   input logic rst_n,
   input logic in_rdy,
   input logic out_rdy,
   input logic dma_in_req,
   input logic dma_out_req,
   input logic core_start,
   input logic core_done,
   input logic busy,
   input logic rst_active
);
   p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |=> !core_start);

   p_start_not_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |-> !in_rdy);

   p_ready_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_rdy && out_rdy));

   p_done_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (core_done && busy && !rst_active) |=> out_rdy);

   p_dma_in_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dma_in_req |-> in_rdy);

   p_dma_out_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dma_out_req |-> out_rdy);

   p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_active |-> (!in_rdy && !out_rdy && !core_start && !dma_in_req));
endmodule

bind cipher_regfront cfe_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_rdy      (in_rdy),
   .out_rdy     (out_rdy),
   .dma_in_req  (dma_in_req),
   .dma_out_req (dma_out_req),
   .core_start  (core_start),
   .core_done   (core_done),
   .busy        (busy_q),
   .rst_active  (rst_act)
);

// File: tb/sim_cipher_regfront.sv
`timescale 1ns/1ps
module sim_cipher_regfront;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   bus_addr = '0;
   logic         bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic         in_rdy, out_rdy, dma_in_req, dma_out_req, core_start, core_encrypt;
   logic [127:0] core_in;
   logic [255:0] core_key;
   logic [1:0]   core_keysz;
   logic         core_done;
   logic [127:0] core_out;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   cipher_regfront u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .in_rdy(in_rdy), .out_rdy(out_rdy),
      .dma_in_req(dma_in_req), .dma_out_req(dma_out_req), .core_start(core_start),
      .core_in(core_in), .core_key(core_key), .core_keysz(core_keysz),
      .core_encrypt(core_encrypt), .core_done(core_done), .core_out(core_out)
   );

   // stub engine: XOR with both key halves, fixed latency
   logic [2:0] stub_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stub_cnt  <= '0;
         core_done <= 1'b0;
         core_out  <= '0;
      end else begin
         core_done <= 1'b0;
         if (core_start) begin
            stub_cnt <= 3'd3;
            core_out <= core_in ^ core_key[127:0] ^ core_key[255:128];
         end else if (stub_cnt != 0) begin
            stub_cnt <= stub_cnt - 3'd1;
            if (stub_cnt == 3'd1) core_done <= 1'b1;
         end
      end
   end

   // table: bit 129 = chaining, bit 128 = encrypt, 127:0 = block
   localparam logic [129:0] VEC [5] = '{
      {1'b0, 1'b1, 128'h00112233_44556677_8899aabb_ccddeeff},
      {1'b1, 1'b1, 128'h0f0e0d0c_0b0a0908_07060504_03020100},
      {1'b1, 1'b1, 128'h13579bdf_2468ace0_fedcba98_76543210},
      {1'b1, 1'b0, 128'h8899aabb_ccddeeff_00112233_44556677},
      {1'b0, 1'b0, 128'hcafef00d_deadbeef_01234567_89abcdef}
   };

   logic [31:0]  kw [8];
   logic [127:0] iv_m;
   logic [31:0]  rd;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bwr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic brd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wait_out();
      for (int n = 0; n < 40 && !out_rdy; n++) @(negedge clk);
   endtask

   function automatic logic [7:0] kaddr(input int i);
      return 8'(28 - ((i ^ 1) * 4));
   endfunction

   function automatic logic [127:0] stub_model(input logic [127:0] b);
      logic [127:0] k;
      for (int j = 0; j < 4; j++) k[32*j +: 32] = kw[j] ^ kw[j+4];
      return b ^ k;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      brd(8'h4C, rd); check("R11 status", rd, 32'h1);
      brd(8'h30, rd); check("R11 ctrl", rd, 32'h2);
      brd(8'h48, rd); check("R11 mask", rd, 32'h0);
      brd(8'h18, rd); check("R11 key0", rd, 32'h0);
      brd(8'h20, rd); check("R11 iv0", rd, 32'h0);
      check("R11 in_rdy", 32'(in_rdy), 32'h1);

      // R3 revision
      brd(8'h44, rd); check("R3 revision", rd, 32'h21);

      // R1 key scramble
      for (int i = 0; i < 8; i++) begin
         kw[i] = 32'h1111_1111 * (i + 1) ^ 32'h5A00_0000;
         bwr(kaddr(i), kw[i]);
      end
      brd(8'h18, rd); check("R1 word0 at 0x18", rd, kw[0]);
      brd(8'h1C, rd); check("R1 word1 at 0x1C", rd, kw[1]);
      brd(8'h04, rd); check("R1 word7 at 0x04", rd, kw[7]);
      brd(8'h00, rd); check("R1 word6 at 0x00", rd, kw[6]);
      for (int i = 0; i < 8; i++) check("R1 core_key lane", core_key[32*i +: 32], kw[i]);

      // R2 control fields
      bwr(8'h30, 32'hFF);
      brd(8'h30, rd); check("R2 ctrl readback", rd, 32'hFE);
      check("R2 keysz", 32'(core_keysz), 32'd3);
      check("R2 encrypt", 32'(core_encrypt), 32'd1);
      bwr(8'h30, 32'h08);
      check("R2 keysz 128", 32'(core_keysz), 32'd1);
      check("R2 decrypt", 32'(core_encrypt), 32'd0);

      // initial chaining vector
      iv_m = 128'h0a0b0c0d_01020304_a1b2c3d4_deadbeef;
      for (int j = 0; j < 4; j++) bwr(8'(32 + 4*j), iv_m[32*j +: 32]);

      // table walk: R4 R5 R6 R7 R8
      for (int v = 0; v < 5; v++) begin
         logic cbc, enc;
         logic [127:0] pt, to_core, res;
         cbc = VEC[v][129];
         enc = VEC[v][128];
         pt  = VEC[v][127:0];
         bwr(8'h30, 32'h18 | (32'(cbc) << 5) | (32'(enc) << 2));
         to_core = (cbc && enc) ? (pt ^ iv_m) : pt;
         res = stub_model(to_core);
         if (cbc && !enc) res = res ^ iv_m;
         for (int j = 0; j < 4; j++) begin
            bwr(8'(52 + 4*j), pt[32*j +: 32]);
            if (j == 0) check("R4 in_rdy low mid-block", 32'(in_rdy), 32'h0);
         end
         check("R4 core_start pulse", 32'(core_start), 32'h1);
         for (int j = 0; j < 4; j++)
            check(cbc && enc ? "R6 core_in" : "R4 core_in", core_in[32*j +: 32], to_core[32*j +: 32]);
         if (v == 0) bwr(8'h34, 32'hBAD0_BAD0);  // R8 stray write while busy
         wait_out();
         check("R5 out_rdy", 32'(out_rdy), 32'h1);
         if (v == 0) bwr(8'h38, 32'hBAD1_BAD1);  // R8 stray write while result pending
         for (int j = 0; j < 4; j++) begin
            brd(8'h34, rd);
            check(cbc && !enc ? "R7 result" : (v == 1 ? "R8 result after stray" : "R5 result"),
                  rd, res[32*j +: 32]);
         end
         check("R5 out_rdy cleared", 32'(out_rdy), 32'h0);
         check("R5 in_rdy back", 32'(in_rdy), 32'h1);
         if (cbc) iv_m = enc ? res : pt;
         for (int j = 0; j < 4; j++) begin
            brd(8'(32 + 4*j), rd);
            check(enc ? "R6 iv update" : "R7 iv update", rd, iv_m[32*j +: 32]);
         end
      end

      // R9 DMA gating
      bwr(8'h30, 32'h1C);
      bwr(8'h48, 32'h0C);
      check("R9 no start no in req", 32'(dma_in_req), 32'h0);
      bwr(8'h48, 32'h2C);
      check("R9 in req", 32'(dma_in_req), 32'h1);
      check("R9 no out req", 32'(dma_out_req), 32'h0);
      brd(8'h48, rd); check("R9 mask readback", rd, 32'h2C);
      for (int j = 0; j < 4; j++) bwr(8'h34, 32'h0101_0101 * (j + 1));
      check("R9 in req drops busy", 32'(dma_in_req), 32'h0);
      wait_out();
      check("R9 out req", 32'(dma_out_req), 32'h1);
      bwr(8'h48, 32'h0C);
      check("R9 start cleared", 32'(dma_out_req), 32'h0);
      for (int j = 0; j < 4; j++) brd(8'h34, rd);
      check("R9 drained", 32'(out_rdy), 32'h0);

      // R10 soft reset
      bwr(8'h48, 32'h02);
      brd(8'h4C, rd); check("R10 status busy", rd, 32'h0);
      brd(8'h48, rd); check("R10 srst bit set", rd, 32'h2);
      check("R10 in_rdy low", 32'(in_rdy), 32'h0);
      bwr(8'h18, 32'hDEAD_BEEF);
      repeat (12) @(negedge clk);
      brd(8'h4C, rd); check("R10 status done", rd, 32'h1);
      brd(8'h48, rd); check("R10 srst self-clear", rd, 32'h0);
      brd(8'h18, rd); check("R10 key cleared, write ignored", rd, 32'h0);
      brd(8'h1C, rd); check("R10 key1 cleared", rd, 32'h0);
      brd(8'h30, rd); check("R10 ctrl cleared", rd, 32'h2);
      brd(8'h20, rd); check("R10 iv cleared", rd, 32'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule